// File: doc/BRIEF.md
# Programmable CRC Engine with Flush Control

This block computes a cyclic redundancy check over a stream of words written through a small register port. The polynomial order and the input word width are each programmable from 1 to 32 bits. Each written word is queued in an eight-entry FIFO. When the engine is idle and running, it pops the head word, stages it for one clock, and then feeds it into the CRC register one bit per clock, most significant bit first.

Two arithmetic modes are available. Direct mode XORs each input bit with the register's top bit, so the register holds the finished CRC once the FIFO has drained. Legacy mode shifts the data into the low end of the register and feeds back only the top bit. Software must then flush the result out by writing one dummy word of zeros whose width equals the polynomial order. A run bit suspends and resumes shifting while writes to the FIFO continue. A sticky interrupt is raised either when all shifting is finished or when the FIFO becomes empty. Writing the seed register reloads the CRC register, and this clears leftover state between calculations.

Top module: `crc_flush_engine`

## Requirements
- R1: After reset, crc_result is 0, fifo_empty is 1, irq and fifo_overflow are 0, and the configuration is all zero, so the run bit is off.
- R2: The write addresses are 0 for push data, 1 for polynomial, 2 for configuration, 3 for seed and 4 for flag clear. The configuration fields are order-minus-one in bits [4:0], width-minus-one in bits [12:8], direct mode in bit 16, interrupt source in bit 17 and run in bit 18.
- R3: The FIFO holds 8 words. A push to a full FIFO is dropped and sets fifo_overflow. This flag stays set until bit 1 is written at address 4.
- R4: When the engine is idle, running and the FIFO is not empty, it pops one word. The word reaches the shift buffer on the next clock, and one bit per clock is shifted from the following clock on, for width bits, MSB first. fifo_empty rises on the clock edge of the pop that empties the FIFO.
- R5: In direct mode, each bit computes fb = in XOR crc[order-1], then crc = ((crc<<1) XOR (fb ? poly : 0)) masked to the order. After the FIFO drains, the register equals the standard CRC of the message with that seed.
- R6: In legacy mode, each bit computes fb = crc[order-1], then crc = (((crc<<1)|in) XOR (fb ? poly : 0)) masked. With a zero seed, a trailing dummy word of order zero bits makes the result equal the direct-mode CRC.
- R7: While the run bit is 0, neither the CRC register nor the bit position changes, and pushes are still accepted. Setting the bit again continues from the same bit.
- R8: With interrupt source 0, irq sets after the final bit of a word when the FIFO is empty. With interrupt source 1, it sets when a pop empties the FIFO. irq stays set until bit 0 is written at address 4, and a set event in the same cycle wins over the clear.
- R9: A write to the seed register loads the CRC register on that edge and overrides any shift in the same cycle.
- R10: crc_result shows the CRC register masked to the programmed order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| crc_result | output | 32 | CRC register masked to order |
| fifo_empty | output | 1 | Data FIFO holds no words |
| fifo_overflow | output | 1 | Sticky dropped-push flag |
| irq | output | 1 | Sticky interrupt flag |

## Verification
Every output depends only on registers. A write that is presented before edge k therefore shows up just after edge k, and a popped word first changes the CRC two edges after its pop. After that, it changes the CRC once per edge for each running cycle. The bench has a behavioural model that steps once on each rising edge, using a queue and integers. The outputs are compared against it at each falling edge, so every comparison falls half a cycle after the edge that produced the value. The final CRC of each message is also checked against a separate bitwise software CRC. For the 8-, 16- and 32-bit cases, this check is made only after the model shows an idle engine and an empty queue.

// File: rtl/crc_flush_pkg.sv
package crc_flush_pkg;
  localparam int unsigned DW = 32;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SHIFT} shift_state_t;

  localparam logic [2:0] ADR_PUSH  = 3'd0;
  localparam logic [2:0] ADR_POLY  = 3'd1;
  localparam logic [2:0] ADR_CFG   = 3'd2;
  localparam logic [2:0] ADR_SEED  = 3'd3;
  localparam logic [2:0] ADR_CLEAR = 3'd4;

  // Ones in the low (m1+1) bits.
  function automatic logic [DW-1:0] order_mask(input logic [4:0] m1);
    return {DW{1'b1}} >> (5'd31 - m1);
  endfunction

  // One bit step; legacy selects the augmented (dummy-flush) form.
  function automatic logic [DW-1:0] crc_next(input logic [DW-1:0] cur,
                                             input logic [DW-1:0] poly,
                                             input logic [4:0]    m1,
                                             input logic          din,
                                             input logic          legacy);
    logic            fb;
    logic [DW-1:0]   nx;
    fb = legacy ? cur[m1] : (cur[m1] ^ din);
    nx = legacy ? {cur[DW-2:0], din} : {cur[DW-2:0], 1'b0};
    if (fb) nx = nx ^ poly;
    return nx & order_mask(m1);
  endfunction
endpackage

// File: rtl/crc_word_fifo.sv
module crc_word_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full,
  output logic         one_left,
  output logic         push_ok
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  logic          pop_ok;

  assign empty    = (count == '0);
  assign full     = (count == CW'(DEPTH));
  assign one_left = (count == CW'(1));
  assign push_ok  = push && !full;
  assign pop_ok   = pop && !empty;
  assign head     = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  p_drop_when_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> full);
endmodule

// File: rtl/crc_bit_shifter.sv
module crc_bit_shifter
  import crc_flush_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          legacy,
  input  logic [4:0]    order_m1,
  input  logic [4:0]    width_m1,
  input  logic [DW-1:0] poly,
  input  logic          q_empty,
  input  logic [DW-1:0] q_head,
  input  logic          seed_wr,
  input  logic [DW-1:0] seed_val,
  output logic          pop,
  output logic          last_bit,
  output logic [DW-1:0] crc
);
  shift_state_t  state;
  logic [DW-1:0] hold, sbuf;
  logic [4:0]    pos;
  logic          step_en;

  assign pop      = (state == ST_IDLE) && run && !q_empty;
  assign step_en  = (state == ST_SHIFT) && run;
  assign last_bit = step_en && (pos == 5'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      hold  <= '0;
      sbuf  <= '0;
      pos   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (pop) begin
          hold  <= q_head;
          state <= ST_LOAD;
        end
        ST_LOAD: begin
          sbuf  <= hold;
          pos   <= width_m1;
          state <= ST_SHIFT;
        end
        default: if (step_en) begin
          if (pos == 5'd0) state <= ST_IDLE;
          else             pos   <= pos - 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       crc <= '0;
    else if (seed_wr) crc <= seed_val;
    else if (step_en) crc <= crc_next(crc, poly, order_m1, sbuf[pos], legacy);
  end

  p_pop_to_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> (state == ST_LOAD));
  p_load_to_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOAD) |=> (state == ST_SHIFT));
  p_suspend_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SHIFT && !run && !seed_wr) |=> ($stable(crc) && $stable(pos)));
  p_seed_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    seed_wr |=> (crc == $past(seed_val)));
endmodule

// File: rtl/crc_flush_engine.sv
module crc_flush_engine
  import crc_flush_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  output logic [31:0] crc_result,
  output logic        fifo_empty,
  output logic        fifo_overflow,
  output logic        irq
);
  logic [DW-1:0] poly_q;
  logic [4:0]    order_m1, width_m1;
  logic          direct_mode, irq_src, run;
  logic          push_req, q_full, q_one, push_ok, pop, last_bit;
  logic [DW-1:0] q_head, crc;
  logic          drained, all_done, irq_set, irq_clr, ovf_clr, drop_evt;

  assign push_req = wr_en && (wr_addr == ADR_PUSH);
  assign irq_clr  = wr_en && (wr_addr == ADR_CLEAR) && wr_data[0];
  assign ovf_clr  = wr_en && (wr_addr == ADR_CLEAR) && wr_data[1];
  assign drop_evt = push_req && q_full;
  assign drained  = pop && q_one && !push_ok;
  assign all_done = last_bit && fifo_empty;
  assign irq_set  = irq_src ? drained : all_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poly_q      <= '0;
      order_m1    <= '0;
      width_m1    <= '0;
      direct_mode <= 1'b0;
      irq_src     <= 1'b0;
      run         <= 1'b0;
    end else if (wr_en && wr_addr == ADR_POLY) begin
      poly_q <= wr_data;
    end else if (wr_en && wr_addr == ADR_CFG) begin
      order_m1    <= wr_data[4:0];
      width_m1    <= wr_data[12:8];
      direct_mode <= wr_data[16];
      irq_src     <= wr_data[17];
      run         <= wr_data[18];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq           <= 1'b0;
      fifo_overflow <= 1'b0;
    end else begin
      irq           <= irq_set  || (irq && !irq_clr);
      fifo_overflow <= drop_evt || (fifo_overflow && !ovf_clr);
    end
  end

  crc_word_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk, .rst_n,
    .push(push_req), .push_data(wr_data), .pop,
    .head(q_head), .empty(fifo_empty), .full(q_full),
    .one_left(q_one), .push_ok
  );

  crc_bit_shifter u_shift (
    .clk, .rst_n, .run, .legacy(!direct_mode),
    .order_m1, .width_m1, .poly(poly_q),
    .q_empty(fifo_empty), .q_head,
    .seed_wr(wr_en && wr_addr == ADR_SEED), .seed_val(wr_data),
    .pop, .last_bit, .crc
  );

  assign crc_result = crc & order_mask(order_m1);

  p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);
  p_irq_needs_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !irq_set) |=> !irq);
  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_overflow && !ovf_clr) |=> fifo_overflow);
  p_no_pop_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty |-> !pop);
endmodule

// File: tb/crc_flush_engine_tb.sv
module crc_flush_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] crc_result;
  logic        fifo_empty, fifo_overflow, irq;

  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  crc_flush_engine u_dut (.*);

  // ---------------- behavioural reference model ----------------
  logic [31:0] q[$];
  logic [31:0] msg[$];
  int          m_st, m_cnt, m_n, m_w;
  logic [31:0] m_crc, m_poly, m_hold, m_sr;
  bit          m_direct, m_isel, m_go, m_irq, m_ovf;

  function automatic longint lmask(int n);
    return (64'd1 << n) - 1;
  endfunction

  function automatic logic [31:0] m_step(logic [31:0] c, logic [31:0] p, int n, bit b, bit direct);
    longint v = c;
    bit top = v[n-1];
    bit fb  = direct ? (top ^ b) : top;
    v = (v << 1) | (direct ? 0 : longint'(b));
    if (fb) v = v ^ longint'(p);
    return 32'(v & lmask(n));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    int sz;
    bit pop, push, pushok, lastb, setirq;
    if (!rst_n) begin
      q.delete();
      m_st = 0; m_cnt = 0; m_n = 1; m_w = 1;
      m_crc = 0; m_poly = 0; m_hold = 0; m_sr = 0;
      m_direct = 0; m_isel = 0; m_go = 0; m_irq = 0; m_ovf = 0;
    end else begin
      sz = q.size();
      pop = (m_st == 0) && m_go && (sz > 0);
      push = wr_en && (wr_addr == 3'd0);
      pushok = push && (sz < 8);
      lastb = 0;
      if (m_st == 2) begin
        if (m_go) begin
          m_crc = m_step(m_crc, m_poly, m_n, m_sr[m_cnt], m_direct);
          if (m_cnt == 0) begin m_st = 0; lastb = 1; end
          else m_cnt--;
        end
      end else if (m_st == 1) begin
        m_sr = m_hold; m_cnt = m_w - 1; m_st = 2;
      end else if (pop) begin
        m_hold = q.pop_front(); m_st = 1;
      end
      if (pushok) q.push_back(wr_data);
      setirq = m_isel ? (pop && sz == 1 && !pushok) : (lastb && sz == 0);
      if (wr_en && wr_addr == 3'd4) begin
        if (wr_data[0]) m_irq = 0;
        if (wr_data[1]) m_ovf = 0;
      end
      if (setirq) m_irq = 1;
      if (push && !pushok) m_ovf = 1;
      if (wr_en && wr_addr == 3'd3) m_crc = wr_data;
      if (wr_en && wr_addr == 3'd1) m_poly = wr_data;
      if (wr_en && wr_addr == 3'd2) begin
        m_n = int'(wr_data[4:0]) + 1; m_w = int'(wr_data[12:8]) + 1;
        m_direct = wr_data[16]; m_isel = wr_data[17]; m_go = wr_data[18];
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison half a cycle after each active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R10 cycle crc_result", crc_result, 32'(longint'(m_crc) & lmask(m_n)));
      chk("R4 cycle fifo_empty", {31'd0, fifo_empty}, {31'd0, q.size() == 0});
      chk("R8 cycle irq", {31'd0, irq}, {31'd0, m_irq});
      chk("R3 cycle overflow", {31'd0, fifo_overflow}, {31'd0, m_ovf});
    end
  end

  // independent bitwise software CRC (direct form)
  function automatic logic [31:0] sw_crc(int n, logic [31:0] p, logic [31:0] seed, int w);
    longint c = longint'(seed) & lmask(n);
    foreach (msg[i]) begin
      for (int b = w - 1; b >= 0; b--) begin
        bit fb = c[n-1] ^ msg[i][b];
        c = (c << 1) & lmask(n);
        if (fb) c = c ^ (longint'(p) & lmask(n));
      end
    end
    return 32'(c);
  endfunction

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic cfg(int n, int w, bit direct, bit isel, bit go);
    wr(3'd2, {13'd0, go, isel, direct, 3'd0, 5'(w - 1), 3'd0, 5'(n - 1)});
  endtask

  task automatic push_word(logic [31:0] d);
    msg.push_back(d);
    wr(3'd0, d);
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(m_st == 0 && q.size() == 0));
    repeat (2) @(negedge clk);
  endtask

  task automatic run_direct(int n, logic [31:0] p, logic [31:0] seed, int w, int cnt, string tag);
    msg.delete();
    wr(3'd1, p);
    cfg(n, w, 1, 1, 1);
    wr(3'd3, seed);
    wr(3'd4, 32'd3);
    for (int i = 0; i < cnt; i++) push_word(32'(longint'(32'h9E37_79B9 * (i + 3) + n) & lmask(w)));
    wait_idle();
    chk(tag, crc_result, sw_crc(n, p, seed, w));
    chk("R8 irq on drain (source 1)", {31'd0, irq}, 32'd1);
  endtask

  task automatic run_legacy(int n, logic [31:0] p, int w, int cnt, string tag);
    msg.delete();
    wr(3'd1, p);
    cfg(n, w, 0, 0, 1);
    wr(3'd3, 32'd0);
    for (int i = 0; i < cnt; i++) push_word(32'((i * 37 + 11) & 255) & 32'(lmask(w)));
    wait_idle();
    wr(3'd4, 32'd1);
    chk("R8 irq cleared", {31'd0, irq}, 32'd0);
    cfg(n, n, 0, 0, 1);
    wr(3'd0, 32'd0);
    wait_idle();
    chk(tag, crc_result, sw_crc(n, p, 32'd0, w));
    chk("R8 irq after all shifts (source 0)", {31'd0, irq}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    chk("R1 reset crc", crc_result, 32'd0);
    chk("R1 reset empty", {31'd0, fifo_empty}, 32'd1);
    chk("R1 reset irq", {31'd0, irq}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    // R1: run bit is off after reset, so a pushed word stays queued
    wr(3'd0, 32'hAB);
    repeat (4) @(negedge clk);
    chk("R1 run off after reset", {31'd0, fifo_empty}, 32'd0);
    wr(3'd3, 32'd0);
    cfg(8, 8, 1, 1, 1);
    wait_idle();

    // R2 / R5 direct-mode CRCs
    run_direct(8, 32'h07, 32'h00, 8, 4, "R5 crc8 direct");
    run_direct(16, 32'h1021, 32'hFFFF, 16, 3, "R5 crc16 direct");
    run_direct(32, 32'h04C1_1DB7, 32'hFFFF_FFFF, 32, 2, "R5 crc32 direct");
    run_direct(32, 32'h04C1_1DB7, 32'hFFFF_FFFF, 8, 5, "R2 crc32 byte width");
    run_direct(5, 32'h05, 32'h1F, 3, 6, "R5 odd order and width");

    // R6 legacy mode with dummy flush
    run_legacy(16, 32'h8005, 8, 4, "R6 crc16 legacy flush");
    run_legacy(8, 32'h31, 8, 3, "R6 crc8 legacy flush");
    run_legacy(32, 32'h04C1_1DB7, 8, 3, "R6 crc32 legacy flush");

    // R3 overflow and R7 suspended pushes
    msg.delete();
    wr(3'd1, 32'h1021);
    cfg(16, 16, 1, 1, 0);
    wr(3'd3, 32'h0);
    for (int i = 0; i < 9; i++) begin
      if (i < 8) msg.push_back(32'(i * 4099 + 1));
      wr(3'd0, 32'(i * 4099 + 1));
    end
    chk("R3 overflow set", {31'd0, fifo_overflow}, 32'd1);
    chk("R7 writes kept while suspended", {31'd0, fifo_empty}, 32'd0);
    cfg(16, 16, 1, 1, 1);
    wait_idle();
    chk("R3 ninth word dropped", crc_result, sw_crc(16, 32'h1021, 32'h0, 16));
    chk("R3 overflow sticky", {31'd0, fifo_overflow}, 32'd1);
    wr(3'd4, 32'd2);
    chk("R3 overflow cleared", {31'd0, fifo_overflow}, 32'd0);

    // R7 suspend mid-word
    msg.delete();
    wr(3'd3, 32'hFFFF);
    push_word(32'hC0DE);
    repeat (6) @(negedge clk);
    cfg(16, 16, 1, 1, 0);
    held = crc_result;
    repeat (10) @(negedge clk);
    chk("R7 crc holds while suspended", crc_result, held);
    cfg(16, 16, 1, 1, 1);
    wait_idle();
    chk("R7 resume completes", crc_result, sw_crc(16, 32'h1021, 32'hFFFF, 16));

    // R9 seed load and R10 masking
    cfg(8, 8, 1, 1, 1);
    wr(3'd3, 32'h1234_5678);
    chk("R9 R10 seed masked to order", crc_result, 32'h78);
    cfg(32, 8, 1, 1, 1);
    chk("R10 full width view", crc_result, 32'h1234_5678);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule